// File: doc/BRIEF.md
# Glitch-Free Differential Clock Stop Controller

This block generates a set of differential output clock pairs from a system clock running at twice the output rate, and parks selected pairs on request without a runt or stretched pulse. Each pair has its own toggle flop. The true output follows the toggle and the complement output is its inverse. All running pairs therefore switch at half the system clock rate.

An active-low stop request arrives from another domain and passes through a two-stage synchronizer. A free-running reference complement clock decides when that synchronizer advances. A configuration mask with one bit per pair decides which pairs obey the synchronized request. A pair that obeys parks with its true output high and its complement low. It enters park only on a rising edge of its true output. When released, it leaves park by dropping the true output, so the first low and high phases after restart are each exactly one system cycle long. A per-pair status output shows which pairs are parked at any moment.

Top module: `clkstop_ctrl`

## Requirements
- R1: While and right after reset, every pair runs with its true output low, its complement output high and its parked flag low. The stop mask resets to all ones, so every pair is stoppable.
- R2: The complement output of every pair is always the inverse of its true output. A running pair inverts its true output on every system clock edge.
- R3: The stop request `stop_n` (0 = stop, 1 = run) is captured by two stages. Both stages shift only at system edges where the internal reference toggle is 1, which are the rising edges of the reference complement clock. The synchronized request is active when the second stage holds 0.
- R4: Bit i of the mask controls pair i. A pair whose mask bit is 0 never parks and keeps toggling while a stop is active.
- R5: A parked pair holds its true output at 1 and its complement at 0, and its `parked` bit is 1.
- R6: A pair enters park only at the edge where its true output goes from 0 to 1. Its true output is never low for two consecutive system cycles.
- R7: A pair leaves park at the first edge where its synchronized request is inactive or its mask bit is 0. At that edge its true output falls, and one cycle later it rises again.
- R8: With `stop_n` held low, every stoppable pair is parked no more than 12 system cycles (six output periods) after `stop_n` falls.
- R9: With `stop_n` held high, every pair has resumed no more than 6 system cycles (three output periods) after `stop_n` rises.
- R10: A mask write (`cfg_we` = 1) loads `cfg_data` while the synchronized request is inactive. While the request is active, a write can only clear mask bits (new mask = old AND data). A cleared bit releases its parked pair at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the output frequency |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_n | input | 1 | Asynchronous active-low stop request |
| cfg_we | input | 1 | Mask write strobe |
| cfg_data | input | NPAIRS | Mask write data, bit i for pair i |
| clk_t | output | NPAIRS | True outputs of the pairs |
| clk_c | output | NPAIRS | Complement outputs of the pairs |
| parked | output | NPAIRS | Per-pair parked status |

## Verification
Assertions check several pulse rules on every cycle: a parked pair sits at a high level, no low phase lasts longer than one cycle, park is entered only from a low phase and left with a falling edge, and unmasked pairs never park. They also check that the synchronizer holds still between reference complement edges and that a write during a stop never sets a mask bit. Only the bench scenarios can show the end-to-end stop and resume latency from the raw request pin. The same holds for the exact phase at which each pair parks under random request and mask traffic, which the bench follows with its own cycle model.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // per-pair generator state
    typedef struct packed {
        logic tgl;   // true output level
        logic park;  // pair frozen high
    } pair_st_t;

    // request synchronizer state
    typedef struct packed {
        logic ref_ph; // free-running reference toggle
        logic s1;     // first capture stage (active-low level)
        logic s2;     // second capture stage (active-low level)
    } sync_st_t;

    localparam sync_st_t SYNC_RST = '{ref_ph: 1'b0, s1: 1'b1, s2: 1'b1};
    localparam pair_st_t PAIR_RST = '{tgl: 1'b0, park: 1'b0};

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_n,
    output logic stop_req
);

    sync_st_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        st_d.ref_ph = ~st_q.ref_ph;
        // advance only when the reference complement is about to rise
        if (st_q.ref_ph) begin
            st_d.s1 = stop_n;
            st_d.s2 = st_q.s1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SYNC_RST;
        else        st_q <= st_d;
    end

    assign stop_req = ~st_q.s2;

    // R3: stages hold between reference complement rising edges
    a_r3_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ref_ph |=> ($stable(st_q.s1) && $stable(st_q.s2)));

    // R3: second stage only takes what the first stage held
    a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ref_ph && $past(rst_n)) |=> (st_q.s2 == $past(st_q.s1)));

endmodule

// File: rtl/clkstop_mask.sv
module clkstop_mask #(
    parameter int NPAIRS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic              cfg_we,
    input  logic [NPAIRS-1:0] cfg_data,
    output logic [NPAIRS-1:0] mask
);

    localparam logic [NPAIRS-1:0] MASK_RST = '1;

    typedef struct packed {
        logic [NPAIRS-1:0] bits;
    } mask_st_t;

    mask_st_t mask_q, mask_d;

    always_comb begin
        mask_d = mask_q;
        if (cfg_we) begin
            if (stop_req) mask_d.bits = mask_q.bits & cfg_data; // clear only
            else          mask_d.bits = cfg_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q.bits <= MASK_RST;
        else        mask_q      <= mask_d;
    end

    assign mask = mask_q.bits;

    // R10: no bit may become set while a stop is in force
    a_r10_no_set_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> ((mask_q.bits & ~$past(mask_q.bits)) == '0));

    // R10: without a write the mask is stable
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(mask_q.bits));

endmodule

// File: rtl/clkstop_pair.sv
module clkstop_pair
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_en,
    output logic ck_t,
    output logic ck_c,
    output logic parked
);

    pair_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.park) begin
            // leave park by starting a full low phase
            if (!stop_en) begin
                st_d.tgl  = 1'b0;
                st_d.park = 1'b0;
            end
        end else begin
            st_d.tgl = ~st_q.tgl;
            // freeze just as the true output rises
            if (stop_en && !st_q.tgl) st_d.park = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PAIR_RST;
        else        st_q <= st_d;
    end

    assign ck_t   = st_q.tgl;
    assign ck_c   = ~st_q.tgl;
    assign parked = st_q.park;

    // R5: a parked pair sits with the true output high
    a_r5_park_high: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.park |-> st_q.tgl);

    // R6: a low phase never lasts two cycles
    a_r6_low_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.tgl |=> st_q.tgl);

    // R6: park is entered only from a low phase
    a_r6_enter_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.park && stop_en && !st_q.tgl) |=> st_q.park);

    // R7: leaving park starts with a falling true output
    a_r7_leave_falling: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.park && !stop_en) |=> (!st_q.park && !st_q.tgl));

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
    parameter int NPAIRS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_n,
    input  logic              cfg_we,
    input  logic [NPAIRS-1:0] cfg_data,
    output logic [NPAIRS-1:0] clk_t,
    output logic [NPAIRS-1:0] clk_c,
    output logic [NPAIRS-1:0] parked
);

    logic              stop_req;
    logic [NPAIRS-1:0] mask;

    clkstop_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_n   (stop_n),
        .stop_req (stop_req)
    );

    clkstop_mask #(.NPAIRS(NPAIRS)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .cfg_we   (cfg_we),
        .cfg_data (cfg_data),
        .mask     (mask)
    );

    for (genvar g = 0; g < NPAIRS; g++) begin : g_pair
        clkstop_pair u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .stop_en (stop_req & mask[g]),
            .ck_t    (clk_t[g]),
            .ck_c    (clk_c[g]),
            .parked  (parked[g])
        );

        // R4: a pair outside the mask is running on the next cycle
        a_r4_unmasked_runs: assert property (@(posedge clk) disable iff (!rst_n)
            !mask[g] |=> !parked[g]);

        // R2: a running pair inverts its true output each edge
        a_r2_running_toggles: assert property (@(posedge clk) disable iff (!rst_n)
            (!parked[g] && !(stop_req && mask[g] && !clk_t[g])) |=> (clk_t[g] != $past(clk_t[g])));
    end

endmodule

// File: tb/tb_clkstop_ctrl.sv
module tb_clkstop_ctrl;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_n = 1'b1;
    logic         cfg_we = 1'b0;
    logic [N-1:0] cfg_data = '0;
    logic [N-1:0] clk_t, clk_c, parked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    clkstop_ctrl #(.NPAIRS(N)) dut (.*);

    always #10 clk = ~clk;

    // bench cycle model, written from the requirements
    logic         m_ref, m_s1, m_s2;
    logic [N-1:0] m_tgl, m_park, m_mask;
    logic [N-1:0] low_prev;

    function automatic logic [N-1:0] next_mask(logic [N-1:0] cur, logic req,
                                                logic we, logic [N-1:0] data);
        if (!we) return cur;
        return req ? (cur & data) : data;   // R10
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ref = 0; m_s1 = 1; m_s2 = 1; m_tgl = '0; m_park = '0; m_mask = '1;
        end else begin
            logic req;
            logic [N-1:0] nt, np;
            req = ~m_s2;
            for (int i = 0; i < N; i++) begin
                logic en;
                en = req & m_mask[i];
                nt[i] = m_tgl[i]; np[i] = m_park[i];
                if (m_park[i]) begin
                    if (!en) begin nt[i] = 0; np[i] = 0; end      // R7
                end else begin
                    nt[i] = ~m_tgl[i];                             // R2
                    if (en && !m_tgl[i]) np[i] = 1;                // R6
                end
            end
            m_mask = next_mask(m_mask, req, cfg_we, cfg_data);
            if (m_ref) begin m_s2 = m_s1; m_s1 = stop_n; end       // R3
            m_ref = ~m_ref;
            m_tgl = nt; m_park = np;
        end
    end

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 R3 R6 R7 true outputs", clk_t, m_tgl);
            chk("R2 complement outputs", clk_c, ~clk_t);
            chk("R4 R5 parked flags", parked, m_park);
            chk("R5 parked level", clk_t & parked, parked);
            chk("R6 low phase length", low_prev & ~clk_t, '0);
            low_prev = ~clk_t;
        end else begin
            low_prev = '0;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mask(logic [N-1:0] v);
        @(negedge clk); cfg_we = 1; cfg_data = v;
        @(negedge clk); cfg_we = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        cyc(3);
        chk("R1 reset true", clk_t, '0);
        chk("R1 reset complement", clk_c, '1);
        chk("R1 reset parked", parked, '0);
        rst_n = 1;
        cyc(4);

        // R1 mask all ones, R8 latency
        stop_n = 0; cyc(12);
        chk("R8 R1 all parked after stop", parked, '1);
        chk("R5 parked true high", clk_t, '1);
        stop_n = 1; cyc(6);
        chk("R9 resumed after release", parked, '0);

        // R4 partial mask
        wr_mask(4'b0101);
        stop_n = 0; cyc(12);
        chk("R4 only masked pairs parked", parked, 4'b0101);
        begin
            logic [N-1:0] a;
            a = clk_t; cyc(1);
            chk("R4 unmasked pairs toggle", (clk_t ^ a) & 4'b1010, 4'b1010);
        end

        // R10 writes during stop
        wr_mask(4'b1111); cyc(12);
        chk("R10 no bit set during stop", parked, 4'b0101);
        wr_mask(4'b0001); cyc(1);
        chk("R10 cleared bit releases pair", parked, 4'b0001);
        stop_n = 1; cyc(6);
        chk("R9 resume", parked, '0);
        wr_mask(4'b1111);

        // random traffic checked against the model
        for (int k = 0; k < 400; k++) begin
            stop_n = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) wr_mask(N'($urandom));
            cyc($urandom_range(1, 14));
        end
        stop_n = 1; cyc(8);
        chk("R9 final all running", parked, '0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule